// File: doc/BRIEF.md
# Bit-Field Extract, Insert and Select Unit

This block is a single-stage datapath unit that works on W-bit words (32 by default). It has three operations. Extract takes a field out of a source word and returns it right-aligned. It can bit-reverse the word first, and it can zero-extend or sign-extend the field. Insert writes the low bits of one source into a field of a base word. Select returns one of two operands, chosen by a predicate that can be inverted.

Extract and insert describe the field with one 16-bit descriptor carried in the low half of `src_b`. The upper byte is the field width and the lower byte is the first bit of the field. A field that runs past the top of the word is cut off at the top bit. Every accepted operation gives one registered result on the cycle after it is accepted. If the caller asks for it, the unit also writes zero and sign flags for extract and insert.

Top module: `bitfield_unit`

## Requirements
- R1: With `in_op`=0 (extract) and `in_signed`=0, the result is bits [start+len-1:start] of `src_a`, zero-extended, where len=`src_b[15:8]` and start=`src_b[7:0]`.
- R2: With `in_op`=0 and `in_signed`=1, the top bit of the extracted field is copied into every result bit above the field.
- R3: With `in_op`=0 and `in_reverse`=1, the field is taken from `src_a` after bit-reversal (bit i moves to bit W-1-i).
- R4: With `in_op`=1 (insert), the result is `src_c` with bits [start+len-1:start] replaced by bits [len-1:0] of `src_a`. All other bits are kept.
- R5: A field width of 0 gives 0 for extract and gives `src_c` unchanged for insert.
- R6: A field that reaches past bit W-1 is cut off at bit W-1. If start ≥ W, extract gives 0, or all ones when signed and bit W-1 of the (possibly reversed) source is 1, and insert gives `src_c`.
- R7: With `in_op[1]`=1 (select), the result is `src_a` when `in_pred` XOR `in_pred_neg` is 1, and `src_b` otherwise.
- R8: `out_valid` is 1 on exactly the cycle after each cycle with `in_valid`=1. `out_result` holds its value while no operation is accepted.
- R9: `out_zero` (result equals 0) and `out_sign` (result bit W-1) are updated together with `out_result`. `out_flag_we` is 1 alongside `out_valid` only when `in_flag_req`=1 and the operation was extract or insert.
- R10: During reset, `out_valid`, `out_flag_we`, `out_result`, `out_zero` and `out_sign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 2 | 0 extract, 1 insert, 2 or 3 select |
| in_signed | input | 1 | Extract sign-extends the field |
| in_reverse | input | 1 | Extract bit-reverses the source first |
| in_flag_req | input | 1 | Request a flag write (extract and insert only) |
| in_pred | input | 1 | Select predicate |
| in_pred_neg | input | 1 | Invert the predicate |
| src_a | input | W | Extract source, insert data, select true operand |
| src_b | input | W | Field descriptor in bits 15:0, or select false operand |
| src_c | input | W | Insert base word |
| out_valid | output | 1 | Result valid |
| out_result | output | W | Registered result |
| out_flag_we | output | 1 | Flag write strobe |
| out_zero | output | 1 | Result is zero |
| out_sign | output | 1 | Result bit W-1 |

## Verification
The bench builds the unit with its defaults: W=32, with both reversal and flag logic generated. The descriptor bytes can therefore name start positions and widths both below and above the word width. Random descriptors with width and start up to 39 hit the clipped fields and the fully out-of-range starts. They also hit the sign fill where the field top bit is bit 31. Operations are issued back to back with mixed opcodes, so the valid lag and the holding of the result register are exercised next to the data paths.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [1:0] {
      BFU_EXTRACT = 2'b00,
      BFU_INSERT  = 2'b01,
      BFU_SELECT  = 2'b10,
      BFU_SELECT2 = 2'b11
   } bfu_op_e;

   localparam int DESC_BYTE_W = 8;
   localparam int DESC_CALC_W = DESC_BYTE_W + 1;
endpackage

// File: rtl/bfu_field_mask.sv
module bfu_field_mask
   import bfu_pkg::*;
#(
   parameter int W  = 32,
   parameter int IW = $clog2(W)
) (
   input  logic [DESC_BYTE_W-1:0] start,
   input  logic [DESC_BYTE_W-1:0] len,
   output logic [W-1:0]           low_mask,
   output logic [W-1:0]           field_mask,
   output logic [IW-1:0]          top_idx,
   output logic                   in_range,
   output logic                   len_zero
);
   logic [DESC_CALC_W-1:0] room;
   logic [DESC_CALC_W-1:0] eff;

   always_comb begin
      in_range = ({1'b0, start} < DESC_CALC_W'(W));
      len_zero = (len == '0);
      room     = DESC_CALC_W'(W) - {1'b0, start};
      if (!in_range)
         eff = '0;
      else if ({1'b0, len} < room)
         eff = {1'b0, len};
      else
         eff = room;
      for (int i = 0; i < W; i++)
         low_mask[i] = (DESC_CALC_W'(i) < eff);
      field_mask = low_mask << start;
      top_idx    = IW'(eff - DESC_CALC_W'(1));
   end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract
   import bfu_pkg::*;
#(
   parameter int W          = 32,
   parameter int IW         = $clog2(W),
   parameter bit REVERSE_EN = 1'b1
) (
   input  logic [W-1:0]           word,
   input  logic                   reverse,
   input  logic                   signed_mode,
   input  logic [DESC_BYTE_W-1:0] start,
   input  logic [W-1:0]           low_mask,
   input  logic [IW-1:0]          top_idx,
   input  logic                   in_range,
   input  logic                   len_zero,
   output logic [W-1:0]           result
);
   logic [W-1:0] src;
   logic [W-1:0] shifted;
   logic         sbit;

   generate
      if (REVERSE_EN) begin : g_rev
         logic [W-1:0] flipped;
         always_comb
            for (int i = 0; i < W; i++)
               flipped[i] = word[W-1-i];
         assign src = reverse ? flipped : word;
      end else begin : g_norev
         logic unused_rev;
         assign unused_rev = reverse;
         assign src        = word;
      end
   endgenerate

   always_comb begin
      shifted = src >> start;
      sbit    = signed_mode & shifted[top_idx];
      if (len_zero)
         result = '0;
      else if (!in_range)
         result = (signed_mode && src[W-1]) ? '1 : '0;
      else
         result = (shifted & low_mask) | (sbit ? ~low_mask : '0);
   end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert
   import bfu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0]           data,
   input  logic [W-1:0]           base,
   input  logic [DESC_BYTE_W-1:0] start,
   input  logic [W-1:0]           field_mask,
   output logic [W-1:0]           result
);
   always_comb
      result = (base & ~field_mask) | ((data << start) & field_mask);
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bfu_pkg::*;
#(
   parameter int W          = 32,
   parameter bit REVERSE_EN = 1'b1,
   parameter bit FLAGS_EN   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [1:0]   in_op,
   input  logic         in_signed,
   input  logic         in_reverse,
   input  logic         in_flag_req,
   input  logic         in_pred,
   input  logic         in_pred_neg,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   input  logic [W-1:0] src_c,
   output logic         out_valid,
   output logic [W-1:0] out_result,
   output logic         out_flag_we,
   output logic         out_zero,
   output logic         out_sign
);
   localparam int IW = $clog2(W);

   generate
      if (W < 16 || W > 128) begin : g_bad_width
         $error("bitfield_unit: W must lie in 16..128");
      end
   endgenerate

   bfu_op_e                op;
   logic [DESC_BYTE_W-1:0] f_start;
   logic [DESC_BYTE_W-1:0] f_len;
   logic [W-1:0]           low_mask;
   logic [W-1:0]           field_mask;
   logic [IW-1:0]          top_idx;
   logic                   in_range;
   logic                   len_zero;
   logic [W-1:0]           ext_res;
   logic [W-1:0]           ins_res;
   logic [W-1:0]           nxt_res;
   logic                   pred_eff;

   assign op      = bfu_op_e'(in_op);
   assign f_len   = src_b[2*DESC_BYTE_W-1:DESC_BYTE_W];
   assign f_start = src_b[DESC_BYTE_W-1:0];

   bfu_field_mask #(.W(W), .IW(IW)) u_mask (
      .start(f_start), .len(f_len), .low_mask(low_mask),
      .field_mask(field_mask), .top_idx(top_idx),
      .in_range(in_range), .len_zero(len_zero)
   );

   bfu_extract #(.W(W), .IW(IW), .REVERSE_EN(REVERSE_EN)) u_ext (
      .word(src_a), .reverse(in_reverse), .signed_mode(in_signed),
      .start(f_start), .low_mask(low_mask), .top_idx(top_idx),
      .in_range(in_range), .len_zero(len_zero), .result(ext_res)
   );

   bfu_insert #(.W(W)) u_ins (
      .data(src_a), .base(src_c), .start(f_start),
      .field_mask(field_mask), .result(ins_res)
   );

   always_comb begin
      pred_eff = in_pred ^ in_pred_neg;
      unique case (op)
         BFU_EXTRACT: nxt_res = ext_res;
         BFU_INSERT:  nxt_res = ins_res;
         BFU_SELECT,
         BFU_SELECT2: nxt_res = pred_eff ? src_a : src_b;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_result <= nxt_res;
      end
   end

   generate
      if (FLAGS_EN) begin : g_flags
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_flag_we <= 1'b0;
               out_zero    <= 1'b0;
               out_sign    <= 1'b0;
            end else begin
               out_flag_we <= in_valid & in_flag_req & ~in_op[1];
               if (in_valid) begin
                  out_zero <= (nxt_res == '0);
                  out_sign <= nxt_res[W-1];
               end
            end
         end

         // R9
         zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_zero == (out_result == '0)));
      end else begin : g_noflags
         assign out_flag_we = 1'b0;
         assign out_zero    = 1'b0;
         assign out_sign    = 1'b0;
      end
   endgenerate

   // R8
   valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   idle_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_result)));
   // R9
   flag_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_we |-> out_valid);
   // R7
   sel_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[1] && (in_pred ^ in_pred_neg)) |=> out_result == $past(src_a));
   // R5
   ext_len0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b00 && src_b[15:8] == 8'd0) |=> out_result == '0);
   // R5
   ins_len0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b01 && src_b[15:8] == 8'd0) |=> out_result == $past(src_c));
endmodule

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid, in_signed, in_reverse, in_flag_req, in_pred, in_pred_neg;
   logic [1:0]   in_op;
   logic [W-1:0] src_a, src_b, src_c;
   logic         out_valid, out_flag_we, out_zero, out_sign;
   logic [W-1:0] out_result;

   always #4 clk = ~clk;

   bitfield_unit u_bitfield_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_signed(in_signed), .in_reverse(in_reverse), .in_flag_req(in_flag_req),
      .in_pred(in_pred), .in_pred_neg(in_pred_neg),
      .src_a(src_a), .src_b(src_b), .src_c(src_c),
      .out_valid(out_valid), .out_result(out_result), .out_flag_we(out_flag_we),
      .out_zero(out_zero), .out_sign(out_sign)
   );

   typedef struct {
      logic [W-1:0] res;
      logic         fwe;
      int           tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;

   function automatic logic [W-1:0] ref_extract(logic [W-1:0] a, logic [15:0] d,
                                                logic sgn, logic rev);
      logic [W-1:0] s, r;
      int len, st, top;
      s = a;
      if (rev) for (int i = 0; i < W; i++) s[i] = a[W-1-i];
      len = int'(d[15:8]); st = int'(d[7:0]); r = '0; top = 0;
      if (len == 0) return '0;
      if (st >= W) return (sgn && s[W-1]) ? '1 : '0;
      for (int i = 0; i < len; i++)
         if (st + i < W) begin r[i] = s[st+i]; top = i; end
      if (sgn && r[top]) for (int j = top + 1; j < W; j++) r[j] = 1'b1;
      return r;
   endfunction

   function automatic logic [W-1:0] ref_insert(logic [W-1:0] a, logic [15:0] d,
                                               logic [W-1:0] c);
      logic [W-1:0] r;
      int len, st;
      r = c; len = int'(d[15:8]); st = int'(d[7:0]);
      for (int i = 0; i < len; i++)
         if (st + i < W) r[st+i] = a[i];
      return r;
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(int tag, logic [1:0] op, logic sgn, logic rev, logic freq,
                        logic p, logic pn, logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] c);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_signed = sgn; in_reverse = rev;
      in_flag_req = freq; in_pred = p; in_pred_neg = pn;
      src_a = a; src_b = b; src_c = c;
      if (op == 2'b00)      e.res = ref_extract(a, b[15:0], sgn, rev);
      else if (op == 2'b01) e.res = ref_insert(a, b[15:0], c);
      else                  e.res = (p ^ pn) ? a : b;
      e.fwe = freq & ~op[1];
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 actual=out_valid 1 expected=out_valid 0");
         end else begin
            exp_t e;
            e = q.pop_front();
            check($sformatf("R%0d result", e.tag), out_result, e.res);
            check("R9 zero", W'(out_zero), W'(e.res == '0));
            check("R9 sign", W'(out_sign), W'(e.res[W-1]));
            check("R9 flag_we", W'(out_flag_we), W'(e.fwe));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] held;
      rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_signed = 1'b0;
      in_reverse = 1'b0; in_flag_req = 1'b0; in_pred = 1'b0; in_pred_neg = 1'b0;
      src_a = '0; src_b = '0; src_c = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 out_valid", W'(out_valid), '0);
      check("R10 out_result", out_result, '0);
      check("R10 flags", W'({out_flag_we, out_zero, out_sign}), '0);
      rst_n = 1'b1;
      idle(2);

      // R1 unsigned extract
      issue(1, 2'b00, 0, 0, 1, 0, 0, 32'hDEADBEEF, 32'h0000_0804, '0);
      issue(1, 2'b00, 0, 0, 0, 0, 0, 32'h8000_0001, 32'h0000_2000, '0);
      // R2 signed extract
      issue(2, 2'b00, 1, 0, 1, 0, 0, 32'hDEADBEEF, 32'h0000_0804, '0);
      issue(2, 2'b00, 1, 0, 0, 0, 0, 32'h0000_0070, 32'h0000_0404, '0);
      // R3 reversed extract
      issue(3, 2'b00, 0, 1, 0, 0, 0, 32'h0000_000F, 32'h0000_0800, '0);
      issue(3, 2'b00, 1, 1, 0, 0, 0, 32'h1234_5678, 32'h0000_0C06, '0);
      // R4 insert
      issue(4, 2'b01, 0, 0, 1, 0, 0, 32'h0000_00FF, 32'h0000_0408, 32'h1234_5678);
      issue(4, 2'b01, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_2000, 32'h0);
      // R5 zero-width field
      issue(5, 2'b00, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0003, '0);
      issue(5, 2'b01, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0005, 32'hCAFE_F00D);
      // R6 clipping and out-of-range start
      issue(6, 2'b00, 1, 0, 0, 0, 0, 32'h8000_0000, 32'h0000_081C, '0);
      issue(6, 2'b00, 1, 0, 0, 0, 0, 32'h8000_0000, 32'h0000_0428, '0);
      issue(6, 2'b00, 0, 0, 0, 0, 0, 32'h8000_0000, 32'h0000_0428, '0);
      issue(6, 2'b00, 1, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h0000_0420, '0);
      issue(6, 2'b01, 0, 0, 0, 0, 0, 32'h0000_00FF, 32'h0000_081E, 32'h0);
      issue(6, 2'b01, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0828, 32'h0BAD_CAFE);
      // R7 select, all predicate combinations, both select codes; R9 no flag write
      issue(7, 2'b10, 0, 0, 1, 1, 0, 32'hAAAA_AAAA, 32'h5555_5555, '0);
      issue(7, 2'b10, 0, 0, 1, 0, 0, 32'hAAAA_AAAA, 32'h5555_5555, '0);
      issue(7, 2'b10, 0, 0, 0, 1, 1, 32'hAAAA_AAAA, 32'h5555_5555, '0);
      issue(7, 2'b11, 0, 0, 0, 0, 1, 32'hAAAA_AAAA, 32'h5555_5555, '0);
      // R9 zero-result extract with flag request
      issue(9, 2'b00, 0, 0, 1, 0, 0, 32'h0000_0000, 32'h0000_1000, '0);

      // mixed random traffic, descriptors reaching past the word
      for (int n = 0; n < 300; n++) begin
         logic [1:0]   op;
         logic [W-1:0] b;
         op = 2'($urandom_range(0, 3));
         b  = $urandom;
         if (op != 2'b10 && op != 2'b11)
            b[15:0] = {8'($urandom_range(0, 39)), 8'($urandom_range(0, 39))};
         issue(op == 2'b00 ? 1 : (op == 2'b01 ? 4 : 7), op,
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               $urandom, b, $urandom);
         if ($urandom_range(0, 7) == 0) idle(1);
      end

      idle(3);
      // R8 hold while idle
      held = out_result;
      idle(4);
      check("R8 idle valid", W'(out_valid), '0);
      check("R8 hold", out_result, held);
      check("R8 queue drained", W'(q.size()), '0);
      finish_run();
   end
endmodule